// File: doc/BRIEF.md
# Sequenced Multiply-Accumulate Unit

This block keeps a running sum of products of unsigned 8-bit operand pairs, such as matrix elements streamed in for a dot product. A transaction starts when the valid strobe is high while the unit is idle. A small four-state controller then steps through three phases. It captures the operands, adds their product into a 32-bit accumulator, and flags completion. Each phase has its own register enable, so operand capture and accumulation never occur in the same cycle.

The caller raises valid together with both operands and keeps the operands steady for one more cycle. In that cycle the operand registers load them. After that the inputs are free to change. The accumulator takes the new sum on the clock edge at the end of the third cycle. In the following cycle `done_o` is high for exactly one cycle, and `acc_o` shows the sum that includes the newest product. The controller is back in idle on the cycle after that. A new pair can therefore be accepted every fourth cycle at best. The accumulator is cleared only by reset.

Top module: `mac_seq_unit`

## Requirements
- R1: While `rst_ni` is low, and right after it is released, `acc_o` is 0 and `done_o` is 0. Reset acts at once, without waiting for a clock edge, and it also aborts any transaction in progress.
- R2: While the unit is idle and `valid_i` is low, `acc_o` and `done_o` stay unchanged, whatever `op_a_i` and `op_b_i` carry.
- R3: A pair is accepted on a rising edge where the unit is idle and `valid_i` is 1. Counting that edge as edge 0, `done_o` is 1 only in the cycle after edge 2, and it is 0 in the cycles after edges 0, 1 and 3.
- R4: In the `done_o` cycle, `acc_o` equals its previous value plus the zero-extended 16-bit product of the operands. The operands are those present in the cycle after edge 0.
- R5: Changes on `op_a_i` and `op_b_i` after the capture cycle (the cycle after edge 0) have no effect on the result of the current transaction.
- R6: `valid_i` is ignored while a transaction is in progress. If `valid_i` is held high, exactly one pair is accepted every four cycles.
- R7: The sum wraps modulo 2^ACC_W (2^32 by default), and no flag is raised.
- R8: `acc_o` changes only on the clock edge just before a `done_o` cycle. It holds its value in all other cycles, including the `done_o` cycle itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; clears all registers |
| valid_i | input | 1 | Starts a transaction when the unit is idle |
| op_a_i | input | OP_W (8) | Unsigned operand A |
| op_b_i | input | OP_W (8) | Unsigned operand B |
| acc_o | output | ACC_W (32) | Running sum of products |
| done_o | output | 1 | One-cycle pulse; acc_o includes the newest product |

## Verification
A table of operand pairs drives the sum through several kinds of product. Zero operands show that an add with no effect does not disturb the sum. A product of 1 and products with one side at 255 expose a wrong or truncated product width. Asymmetric pairs catch swapped operands or an operand that is dropped. The operands are changed during the processing cycle, which separates capture in the load phase from any later sampling. Holding valid high for eight cycles checks that exactly two products are added, which separates correct ignoring of valid from re-triggering. A narrow-accumulator instance, driven with repeated 255×255 pairs, shows wrapping. A reset in the middle of a transaction shows that clearing does not wait for the transaction to finish.

// File: rtl/mac_seq_pkg.sv
package mac_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROC = 2'd2,
    ST_DONE = 2'd3
  } mac_state_e;
endpackage

// File: rtl/mac_en_reg.sv
module mac_en_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/mac_seq_ctrl.sv
module mac_seq_ctrl
  import mac_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic ld_ops_o,
  output logic acc_en_o,
  output logic done_o
);
  mac_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (valid_i) state_d = ST_LOAD;
      ST_LOAD: state_d = ST_PROC;
      ST_PROC: state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign ld_ops_o = (state_q == ST_LOAD);
  assign acc_en_o = (state_q == ST_PROC);
  assign done_o   = (state_q == ST_DONE);

  AST_IDLE_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !valid_i) |=> state_q == ST_IDLE); // R2
  AST_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && valid_i) |=> state_q == ST_LOAD); // R6
  AST_LOAD_TO_PROC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_LOAD |=> state_q == ST_PROC); // R3
  AST_PROC_TO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_PROC |=> state_q == ST_DONE); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3
  AST_ENABLES_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ld_ops_o, acc_en_o, done_o}) <= 1); // R6
endmodule

// File: rtl/mac_seq_dp.sv
module mac_seq_dp #(
  parameter int unsigned OP_W  = 8,
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_ops_i,
  input  logic             acc_en_i,
  input  logic [OP_W-1:0]  op_a_i,
  input  logic [OP_W-1:0]  op_b_i,
  output logic [ACC_W-1:0] acc_o
);
  localparam int unsigned PROD_W = 2 * OP_W;
  localparam int unsigned PAD_W  = ACC_W - PROD_W;

  logic [OP_W-1:0]   a_q, b_q;
  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  sum;

  mac_en_reg #(.W(OP_W)) u_reg_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(ld_ops_i), .d_i(op_a_i), .q_o(a_q));
  mac_en_reg #(.W(OP_W)) u_reg_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(ld_ops_i), .d_i(op_b_i), .q_o(b_q));

  assign prod = a_q * b_q;
  // zero-extend, wrap modulo 2^ACC_W
  assign sum  = acc_o + {{PAD_W{1'b0}}, prod};

  mac_en_reg #(.W(ACC_W)) u_reg_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(acc_en_i), .d_i(sum), .q_o(acc_o));

  AST_OPS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_ops_i |=> ($stable(a_q) && $stable(b_q))); // R5
  AST_ACC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_en_i |=> $stable(acc_o)); // R8
  AST_ACC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i |=> acc_o == $past(acc_o) + ACC_W'($past(a_q) * $past(b_q))); // R4
endmodule

// File: rtl/mac_seq_unit.sv
module mac_seq_unit #(
  parameter int unsigned OP_W  = 8,
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OP_W-1:0]  op_a_i,
  input  logic [OP_W-1:0]  op_b_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             done_o
);
  logic ld_ops, acc_en;

  mac_seq_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .ld_ops_o(ld_ops), .acc_en_o(acc_en), .done_o(done_o));

  mac_seq_dp #(.OP_W(OP_W), .ACC_W(ACC_W)) u_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_ops_i(ld_ops), .acc_en_i(acc_en),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .acc_o(acc_o));

  AST_ACC_MOVES_BEFORE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(acc_o) |-> done_o); // R8
endmodule

// File: tb/tb_mac_seq_unit.sv
module tb_mac_seq_unit;
  localparam int unsigned NW = 18;
  localparam int N = 8;
  localparam logic [7:0] TA [N] = '{8'd0,   8'd1, 8'd255, 8'd7,  8'd255, 8'd12, 8'd200, 8'd3};
  localparam logic [7:0] TB [N] = '{8'd77,  8'd1, 8'd2,   8'd9,  8'd255, 8'd0,  8'd13,  8'd128};

  logic clk = 1'b0, rst_n = 1'b0, valid = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic [31:0] y;
  logic [NW-1:0] y_n;
  logic done, done_n;
  int errs = 0, checks = 0;
  logic [31:0] exp_acc = '0;

  always #5 clk = ~clk;

  mac_seq_unit dut (.clk_i(clk), .rst_ni(rst_n), .valid_i(valid),
    .op_a_i(a), .op_b_i(b), .acc_o(y), .done_o(done));
  mac_seq_unit #(.ACC_W(NW)) dut_n (.clk_i(clk), .rst_ni(rst_n), .valid_i(valid),
    .op_a_i(a), .op_b_i(b), .acc_o(y_n), .done_o(done_n));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic run(logic [7:0] pa, logic [7:0] pb);
    logic [31:0] prev = exp_acc;
    exp_acc = exp_acc + 32'(pa) * 32'(pb);
    valid = 1'b1; a = pa; b = pb;
    cyc();                       // edge 0 -> capture cycle
    valid = 1'b0;
    check("R3 done in capture", {31'd0, done}, 0);
    check("R8 acc held in capture", y, prev);
    cyc();                       // edge 1 -> processing
    a = ~pa; b = pb + 8'd1;      // R5: late operand change
    check("R3 done in processing", {31'd0, done}, 0);
    check("R8 acc held in processing", y, prev);
    cyc();                       // edge 2 -> done cycle
    check("R3 done pulse", {31'd0, done}, 1);
    check("R4 R5 sum in done", y, exp_acc);
    cyc();                       // edge 3 -> idle
    check("R3 done drops", {31'd0, done}, 0);
    check("R8 acc held after done", y, exp_acc);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1 reset acc", y, 0);
    check("R1 reset done", {31'd0, done}, 0);
    cyc();
    rst_n = 1'b1;
    cyc();
    check("R1 acc after release", y, 0);

    // R2: idle with valid low, operands toggling
    for (int i = 0; i < 4; i++) begin
      a = 8'(i * 37 + 5); b = 8'(i * 11 + 200);
      cyc();
      check("R2 idle acc", y, 0);
      check("R2 idle done", {31'd0, done}, 0);
    end

    for (int i = 0; i < N; i++) run(TA[i], TB[i]);

    // R6: valid held high for 8 cycles -> two transactions
    begin
      int dones = 0;
      valid = 1'b1; a = 8'd3; b = 8'd5;
      for (int i = 0; i < 8; i++) begin
        cyc();
        if (done) dones++;
      end
      valid = 1'b0;
      exp_acc = exp_acc + 32'd30;
      check("R6 pulses with valid held", 32'(dones), 2);
      check("R6 sum with valid held", y, exp_acc);
    end

    // R1: reset in the middle of a transaction
    valid = 1'b1; a = 8'd9; b = 8'd9;
    cyc();
    valid = 1'b0;
    cyc();
    #2 rst_n = 1'b0;
    #1 check("R1 async clear acc", y, 0);
    check("R1 async clear done", {31'd0, done}, 0);
    cyc();
    rst_n = 1'b1;
    cyc(); cyc(); cyc();
    check("R1 aborted run leaves no pulse", {31'd0, done}, 0);
    check("R1 aborted run leaves acc", y, 0);
    exp_acc = '0;

    // R7: wrap on the narrow instance
    for (int i = 0; i < 5; i++) run(8'd255, 8'd255);
    check("R7 wide no wrap", y, 32'd325125);
    check("R7 narrow wrap", 32'(y_n), 32'((5 * 65025) % (1 << NW)));

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule